// File: doc/BRIEF.md
# Round-Robin Next-PC Sequencer with Per-Thread Call Stacks

This block holds the program counters of four hardware threads and chooses, each cycle, the next program counter of the thread that is issuing. Threads take turns in a fixed rotation, one per clock. The issuing thread's counter is presented as the fetch address, together with its thread number. In the same cycle, the surrounding core supplies the 3-bit branch field and the 10-bit immediate of that thread's instruction. It also supplies the low ten bits of the result that thread's previous instruction produced, and that result's sign.

On the clock edge the block writes the selected target into the issuing thread's counter and advances to the next thread. The possible targets are the sequential successor, the top of the thread's own return stack, the immediate, or the previous result. The sequential successor increments only the low eight bits and stays inside a 256-word page. Calls push the sequential successor onto an 8-entry, 16-bit return stack. Returns pop that stack. Each thread has its own stack, and each stack pointer wraps in a circle.

The thread rotation is a four-state machine with states SLOT0, SLOT1, SLOT2 and SLOT3. Its transitions are SLOT0→SLOT1, SLOT1→SLOT2, SLOT2→SLOT3 and SLOT3→SLOT0, one transition on every clock. Reset forces the machine to SLOT0.

Top module: `rrpc_seq`

## Requirements
- R1: While reset is low and after it is released, every thread's counter is 0, every stack pointer is 0, `thread_id` is 0 and `fetch_pc` is 0.
- R2: `thread_id` advances 0,1,2,3,0,… by one on every clock edge after reset, and `fetch_pc` always shows the counter of thread `thread_id`.
- R3: Branch field 000 (none) sets the thread's next counter to bits 9:8 unchanged and bits 7:0 plus one modulo 256, so 0x2FF is followed by 0x200.
- R4: Branch field 110 sets the next counter to `br_imm`.
- R5: Branch field 111 sets the next counter to `p_low`.
- R6: Branch field 100 sets the next counter to `br_imm` when `p_sign` is 1, and to the sequential successor otherwise.
- R7: Branch field 101 sets the next counter to `br_imm` when `p_sign` is 0, and to the sequential successor otherwise.
- R8: Branch field 010 pushes the sequential successor onto the thread's stack and sets the next counter to `br_imm`.
- R9: Branch field 011 pushes the sequential successor and sets the next counter to `p_low`.
- R10: Branch field 001 pops the thread's stack and sets the next counter to the most recently pushed entry that has not yet been popped, in last-in first-out order.
- R11: The stack pointer is a 3-bit circular pointer. A ninth push without a pop overwrites the oldest entry, and popping past the bottom wraps to the top slot.
- R12: A thread's counter and stack change only in that thread's own issue slot. Branches, calls and returns by other threads do not alter them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_kind | input | 3 | Branch field of the issuing thread's instruction |
| br_imm | input | 10 | Immediate target of that instruction |
| p_low | input | 10 | Low ten bits of that thread's previous result |
| p_sign | input | 1 | Sign bit of that previous result |
| fetch_pc | output | 10 | Counter of the issuing thread |
| thread_id | output | 2 | Number of the issuing thread |

## Verification
In a single cycle, a stack push or pop by the issuing thread coincides with the rotation to the next thread's context. That same cycle may also be a page wrap, for example a call issued at a counter ending in 0xFF, whose pushed successor must wrap within its page. The bench provokes this collision by interleaving calls and returns on one thread with different stack work on the other three. It also drives a ninth nested call into a full stack and jumps to page ends before calls. Every returned address is compared with a bench model that keeps a separate circular stack and counter for each thread.

// File: rtl/rrpc_pkg.sv
package rrpc_pkg;
    localparam int NTHR   = 4;
    localparam int TW     = 2;
    localparam int PCW    = 10;
    localparam int PAGEW  = 8;
    localparam int SDEPTH = 8;
    localparam int SPW    = 3;
    localparam int SEW    = 16;

    typedef enum logic [2:0] {
        BR_NONE  = 3'd0,
        BR_RET   = 3'd1,
        BR_CALLI = 3'd2,
        BR_CALLP = 3'd3,
        BR_JNEG  = 3'd4,
        BR_JPOS  = 3'd5,
        BR_JI    = 3'd6,
        BR_JP    = 3'd7
    } br_e;

    typedef enum logic [1:0] {
        SLOT0 = 2'd0,
        SLOT1 = 2'd1,
        SLOT2 = 2'd2,
        SLOT3 = 2'd3
    } slot_e;
endpackage

// File: rtl/rrpc_sched.sv
module rrpc_sched
    import rrpc_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    output logic [TW-1:0] tid_o
);
    slot_e st_q, st_n;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= SLOT0;
        else        st_q <= st_n;
    end

    always_comb begin
        st_n = SLOT0;
        unique case (st_q)
            SLOT0: st_n = SLOT1;
            SLOT1: st_n = SLOT2;
            SLOT2: st_n = SLOT3;
            SLOT3: st_n = SLOT0;
            default: st_n = SLOT0;
        endcase
    end

    always_comb begin
        tid_o = '0;
        unique case (st_q)
            SLOT0: tid_o = 2'd0;
            SLOT1: tid_o = 2'd1;
            SLOT2: tid_o = 2'd2;
            SLOT3: tid_o = 2'd3;
            default: tid_o = 2'd0;
        endcase
    end

    p_rotate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (tid_o == $past(tid_o) + 2'd1));
endmodule

// File: rtl/rrpc_decode.sv
module rrpc_decode
    import rrpc_pkg::*;
(
    input  br_e            kind_i,
    input  logic [PCW-1:0] cur_pc_i,
    input  logic [PCW-1:0] top_i,
    input  logic [PCW-1:0] imm_i,
    input  logic [PCW-1:0] p_i,
    input  logic           sign_i,
    output logic [PCW-1:0] next_pc_o,
    output logic [PCW-1:0] seq_pc_o,
    output logic           push_o,
    output logic           pop_o
);
    logic [PAGEW-1:0] low_inc;

    always_comb begin
        low_inc  = cur_pc_i[PAGEW-1:0] + 1'b1;
        seq_pc_o = {cur_pc_i[PCW-1:PAGEW], low_inc};
    end

    always_comb begin
        next_pc_o = seq_pc_o;
        push_o    = 1'b0;
        pop_o     = 1'b0;
        unique case (kind_i)
            BR_NONE:  next_pc_o = seq_pc_o;
            BR_RET: begin
                next_pc_o = top_i;
                pop_o     = 1'b1;
            end
            BR_CALLI: begin
                next_pc_o = imm_i;
                push_o    = 1'b1;
            end
            BR_CALLP: begin
                next_pc_o = p_i;
                push_o    = 1'b1;
            end
            BR_JNEG:  next_pc_o = sign_i ? imm_i : seq_pc_o;
            BR_JPOS:  next_pc_o = sign_i ? seq_pc_o : imm_i;
            BR_JI:    next_pc_o = imm_i;
            BR_JP:    next_pc_o = p_i;
            default:  next_pc_o = seq_pc_o;
        endcase
    end
endmodule

// File: rtl/rrpc_stack.sv
module rrpc_stack
    import rrpc_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [TW-1:0]  tid_i,
    input  logic           push_i,
    input  logic           pop_i,
    input  logic [PCW-1:0] push_pc_i,
    output logic [PCW-1:0] top_o
);
    logic [SEW-1:0] mem_q [NTHR][SDEPTH];
    logic [SPW-1:0] sp_q  [NTHR];
    logic [SPW-1:0] rd_idx;
    logic [SEW-1:0] top_ent;

    always_comb begin
        rd_idx  = sp_q[tid_i] - 1'b1;
        top_ent = mem_q[tid_i][rd_idx];
        top_o   = top_ent[PCW-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < NTHR; t++) begin
                sp_q[t] <= '0;
                for (int e = 0; e < SDEPTH; e++) mem_q[t][e] <= '0;
            end
        end else if (push_i) begin
            mem_q[tid_i][sp_q[tid_i]] <= {{(SEW-PCW){1'b0}}, push_pc_i};
            sp_q[tid_i]               <= sp_q[tid_i] + 1'b1;
        end else if (pop_i) begin
            sp_q[tid_i] <= rd_idx;
        end
    end

    p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_i && pop_i));
    p_hi_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> (top_ent[SEW-1:PCW] == '0));
endmodule

// File: rtl/rrpc_ctx.sv
module rrpc_ctx
    import rrpc_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [TW-1:0]  tid_i,
    input  logic [PCW-1:0] next_pc_i,
    output logic [PCW-1:0] cur_pc_o
);
    logic [NTHR-1:0][PCW-1:0] pc_all;

    for (genvar t = 0; t < NTHR; t++) begin : g_thr
        logic [PCW-1:0] pc_r;
        always_ff @(posedge clk) begin
            if (!rst_n)                    pc_r <= '0;
            else if (tid_i == TW'(t))      pc_r <= next_pc_i;
        end
        assign pc_all[t] = pc_r;
    end

    assign cur_pc_o = pc_all[tid_i];
endmodule

// File: rtl/rrpc_seq.sv
module rrpc_seq
    import rrpc_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [2:0]     br_kind,
    input  logic [PCW-1:0] br_imm,
    input  logic [PCW-1:0] p_low,
    input  logic           p_sign,
    output logic [PCW-1:0] fetch_pc,
    output logic [TW-1:0]  thread_id
);
    logic [TW-1:0]  tid;
    logic [PCW-1:0] cur_pc, next_pc, seq_pc, top_pc;
    logic           push, pop;
    br_e            kind;

    assign kind = br_e'(br_kind);

    rrpc_sched u_sched (.clk(clk), .rst_n(rst_n), .tid_o(tid));

    rrpc_ctx u_ctx (
        .clk(clk), .rst_n(rst_n), .tid_i(tid),
        .next_pc_i(next_pc), .cur_pc_o(cur_pc)
    );

    rrpc_decode u_dec (
        .kind_i(kind), .cur_pc_i(cur_pc), .top_i(top_pc), .imm_i(br_imm),
        .p_i(p_low), .sign_i(p_sign), .next_pc_o(next_pc),
        .seq_pc_o(seq_pc), .push_o(push), .pop_o(pop)
    );

    rrpc_stack u_stk (
        .clk(clk), .rst_n(rst_n), .tid_i(tid), .push_i(push), .pop_i(pop),
        .push_pc_i(seq_pc), .top_o(top_pc)
    );

    assign fetch_pc  = cur_pc;
    assign thread_id = tid;

    p_page_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (br_kind == 3'd0) |-> ##4
        (fetch_pc[PCW-1:PAGEW] == $past(fetch_pc[PCW-1:PAGEW], 4) &&
         fetch_pc[PAGEW-1:0] == $past(fetch_pc[PAGEW-1:0], 4) + 1'b1));
    p_jimm_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (br_kind == 3'd6) |-> ##4 (fetch_pc == $past(br_imm, 4)));
    p_jp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (br_kind == 3'd7) |-> ##4 (fetch_pc == $past(p_low, 4)));
    p_cond_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (br_kind == 3'd4 && p_sign) |-> ##4 (fetch_pc == $past(br_imm, 4)));
    p_cond_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (br_kind == 3'd5 && !p_sign) |-> ##4 (fetch_pc == $past(br_imm, 4)));
endmodule

// File: tb/sim_rrpc_seq.sv
module sim_rrpc_seq;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] br_kind;
    logic [9:0] br_imm, p_low;
    logic       p_sign;
    logic [9:0] fetch_pc;
    logic [1:0] thread_id;

    int nchk = 0, nerr = 0;

    logic [9:0]  mpc [4];
    logic [15:0] mstk [4][8];
    logic [2:0]  msp [4];
    logic [1:0]  mtid;
    string       lastreq [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    rrpc_seq u0 (.clk(clk), .rst_n(rst_n), .br_kind(br_kind), .br_imm(br_imm),
                 .p_low(p_low), .p_sign(p_sign), .fetch_pc(fetch_pc),
                 .thread_id(thread_id));

    function automatic string req_of(input logic [2:0] k);
        case (k)
            3'd0: return "R3";
            3'd1: return "R10";
            3'd2: return "R8";
            3'd3: return "R9";
            3'd4: return "R6";
            3'd5: return "R7";
            3'd6: return "R4";
            default: return "R5";
        endcase
    endfunction

    function automatic logic [9:0] seq_of(input logic [9:0] pc);
        return {pc[9:8], pc[7:0] + 8'd1};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // called just after a falling edge
    task automatic step(input logic [2:0] k, input logic [9:0] im,
                        input logic [9:0] p, input logic s, input string tag);
        logic [1:0] t;
        logic [9:0] nx, sq;
        t = mtid;
        check(thread_id == mtid, "R2", thread_id, mtid);
        check(fetch_pc == mpc[t], lastreq[t], fetch_pc, mpc[t]);
        br_kind = k; br_imm = im; p_low = p; p_sign = s;
        sq = seq_of(mpc[t]);
        nx = sq;
        case (k)
            3'd1: begin msp[t] = msp[t] - 3'd1; nx = mstk[t][msp[t]][9:0]; end
            3'd2: begin mstk[t][msp[t]] = {6'd0, sq}; msp[t] = msp[t] + 3'd1; nx = im; end
            3'd3: begin mstk[t][msp[t]] = {6'd0, sq}; msp[t] = msp[t] + 3'd1; nx = p; end
            3'd4: nx = s ? im : sq;
            3'd5: nx = s ? sq : im;
            3'd6: nx = im;
            3'd7: nx = p;
            default: nx = sq;
        endcase
        @(posedge clk);
        mpc[t] = nx;
        lastreq[t] = (tag != "") ? tag : req_of(k);
        mtid = mtid + 2'd1;
        @(negedge clk);
    endtask

    task automatic thr(input logic [1:0] t, input logic [2:0] k, input logic [9:0] im,
                       input logic [9:0] p, input logic s, input string tag);
        while (mtid != t) step(3'd0, 10'd0, 10'd0, 1'b0, "");
        step(k, im, p, s, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        nerr++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    end

    initial begin
        void'($urandom(32'd20231));
        rst_n = 1'b0; br_kind = 3'd0; br_imm = '0; p_low = '0; p_sign = 1'b0;
        for (int t = 0; t < 4; t++) begin
            mpc[t] = '0; msp[t] = '0; lastreq[t] = "R1";
            for (int e = 0; e < 8; e++) mstk[t][e] = '0;
        end
        mtid = 2'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(fetch_pc == 10'd0, "R1", fetch_pc, 0);
        check(thread_id == 2'd0, "R1", thread_id, 0);
        rst_n = 1'b1;

        // R1: first rotation shows reset counters
        for (int i = 0; i < 4; i++) step(3'd0, 10'd0, 10'd0, 1'b0, "");
        // R3: page wrap
        thr(0, 3'd6, 10'h2FF, 10'd0, 1'b0, "");
        thr(0, 3'd0, 10'd0, 10'd0, 1'b0, "R3");
        // R6 / R7
        thr(1, 3'd4, 10'h155, 10'h0AA, 1'b1, "R6");
        thr(1, 3'd4, 10'h0F0, 10'h0AA, 1'b0, "R6");
        thr(2, 3'd5, 10'h1C3, 10'h0AA, 1'b0, "R7");
        thr(2, 3'd5, 10'h0F0, 10'h0AA, 1'b1, "R7");
        // R5, R9, R8, R10
        thr(3, 3'd7, 10'h3AB, 10'h3AB, 1'b0, "R5");
        thr(3, 3'd3, 10'h000, 10'h100, 1'b0, "R9");
        thr(3, 3'd2, 10'h080, 10'h000, 1'b0, "R8");
        thr(3, 3'd1, 10'h000, 10'h000, 1'b0, "R10");
        thr(3, 3'd1, 10'h000, 10'h000, 1'b0, "R10");
        // call at page end: pushed successor wraps in page
        thr(0, 3'd6, 10'h1FF, 10'd0, 1'b0, "");
        thr(0, 3'd2, 10'h010, 10'd0, 1'b0, "R8");
        thr(0, 3'd1, 10'h000, 10'd0, 1'b0, "R10");
        // R11: overflow and underflow wrap on thread 2
        for (int i = 0; i < 9; i++)
            thr(2, 3'd2, 10'($urandom), 10'd0, 1'b0, "R11");
        for (int i = 0; i < 10; i++)
            thr(2, 3'd1, 10'd0, 10'd0, 1'b0, "R11");
        // R12: interleaved stack work on other threads
        thr(0, 3'd2, 10'h040, 10'd0, 1'b0, "");
        thr(1, 3'd2, 10'h3C0, 10'd0, 1'b0, "R12");
        thr(2, 3'd3, 10'd0, 10'h2A0, 1'b0, "R12");
        thr(1, 3'd1, 10'd0, 10'd0, 1'b0, "R12");
        thr(3, 3'd1, 10'd0, 10'd0, 1'b0, "R12");
        thr(0, 3'd1, 10'd0, 10'd0, 1'b0, "R12");
        thr(0, 3'd0, 10'd0, 10'd0, 1'b0, "R12");

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            logic [2:0] k;
            k = 3'($urandom);
            if (($urandom % 4) == 0) k = 3'd0;
            step(k, 10'($urandom), 10'($urandom), 1'($urandom), "");
        end
        for (int i = 0; i < 4; i++) step(3'd0, 10'd0, 10'd0, 1'b0, "");

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    end
endmodule